// File: doc/BRIEF.md
# Clocked Burst Parallel Byte Port

This block sits on the device side of an 8-bit parallel byte link. The link is clocked. The device runs from its own clock and hands that clock to the host unchanged. The host samples the device flags and drives its strobes in step with that clock.

Three active-low host strobes control the port:
- **Output enable** lets the device place read data on the shared bus.
- **Read** takes bytes from the device.
- **Write** delivers bytes into the device.

While a strobe is held low, one byte moves on every clock edge. Two active-low flags pace the host. The receive flag says a byte is waiting to be read. The transmit flag says there is room to accept a byte.

Inside the chip, the port connects to a byte source and a byte sink through valid/ready streams. The source feeds bytes toward the host and the sink takes bytes written by the host. A single holding register prefetches the next byte for the host, so data is on the bus as soon as output enable has been seen. A small buffer on the write side absorbs bursts while the internal sink is stalled.

The bus is shared and half duplex. It is modelled as a separate input, output and drive-enable.

Top module: `burst_fifo_port`

## Requirements
- R1: While and right after reset: `rxf_n` is high, `txe_n` is low (room available), `bus_drive` is low and `tx_valid` is low.
- R2: While no byte is held, `rx_ready` is high. A byte accepted from the rx stream on an edge makes `rxf_n` low and appears on `bus_out` after that same edge, with no host strobe needed.
- R3: A read transfer happens on an edge where `host_rd_n`, `host_oe_n` and `rxf_n` are all low. During a burst, the next byte from the rx stream is presented after every such edge, and bytes reach the host in the order the rx stream supplied them.
- R4: When the edge that takes the held byte finds no further byte offered, `rxf_n` goes high right after that edge. `rxf_n` never rises without a read on the previous edge.
- R5: `bus_drive` is high in a cycle exactly when the previous edge sampled `host_oe_n` low.
- R6: With `host_oe_n` high, a low `host_rd_n` moves no byte: `rxf_n` stays low and `bus_out` holds its value.
- R7: A write capture happens on an edge where `host_wr_n` and `txe_n` are low and no read is claimed. Captured bytes leave on the tx stream in capture order, and `tx_data` stays stable while `tx_valid` is high and `tx_ready` is low.
- R8: `txe_n` goes high once TX_DEPTH bytes are buffered. Writes while `txe_n` is high are discarded. A full buffer stays full until the sink takes a byte.
- R9: When `host_rd_n`, `host_wr_n` and `host_oe_n` are all low, the write is ignored and only the read may happen. With `host_oe_n` high, the same strobes perform the write.

Ports appear below in the order of the port list.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clk_out | output | 1 | Clock exported to the host |
| host_oe_n | input | 1 | Host output enable, active low |
| host_rd_n | input | 1 | Host read strobe, active low |
| host_wr_n | input | 1 | Host write strobe, active low |
| bus_in | input | DW | Byte driven by the host on the shared bus |
| bus_out | output | DW | Byte the device presents for reading |
| bus_drive | output | 1 | Device drives the shared bus when high |
| rxf_n | output | 1 | Low while a byte is available to read |
| txe_n | output | 1 | Low while a byte can be written |
| rx_data | input | DW | Internal source byte |
| rx_valid | input | 1 | Internal source byte valid |
| rx_ready | output | 1 | Port accepts the source byte |
| tx_data | output | DW | Byte delivered to the internal sink |
| tx_valid | output | 1 | Sink byte valid |
| tx_ready | input | 1 | Sink accepts the byte |

## Verification
The bench goes after four corner cases.

- **End of a read burst.** A port that held the flag low one cycle too long would make the host take a stale or duplicate byte. The bench checks the exact edge at which `rxf_n` rises.
- **Read without output enable.** A port that ignored output enable would lose a byte from the stream. The bench checks that a low `host_rd_n` with `host_oe_n` high moves nothing.
- **Writes into a full buffer.** A port that accepted them would overwrite queued data, and the drained stream would then disagree with the reference queue.
- **Read and write asserted together.** A port without read priority would capture bytes from a bus it is driving itself. The bench checks this both with `host_oe_n` low and with `host_oe_n` high.

// File: rtl/burst_fifo_port.sv
module burst_fifo_port #(
  parameter int DW       = 8,
  parameter int TX_DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic          clk_out,
  input  logic          host_oe_n,
  input  logic          host_rd_n,
  input  logic          host_wr_n,
  input  logic [DW-1:0] bus_in,
  output logic [DW-1:0] bus_out,
  output logic          bus_drive,
  output logic          rxf_n,
  output logic          txe_n,
  input  logic [DW-1:0] rx_data,
  input  logic          rx_valid,
  output logic          rx_ready,
  output logic [DW-1:0] tx_data,
  output logic          tx_valid,
  input  logic          tx_ready
);

  localparam int PTR_W = (TX_DEPTH > 1) ? $clog2(TX_DEPTH) : 1;
  localparam int CNT_W = $clog2(TX_DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(TX_DEPTH);

  logic          hold_vld;
  logic [DW-1:0] hold_data;
  logic          oe_q;
  logic [DW-1:0] mem [TX_DEPTH];
  logic [PTR_W-1:0] wptr, rptr;
  logic [CNT_W-1:0] cnt;

  logic rd_claim, rd_take, wr_take, tx_pop, rx_load;

  assign clk_out   = clk;
  assign rd_claim  = !host_rd_n && !host_oe_n;
  assign rd_take   = rd_claim && hold_vld;
  assign rx_ready  = !hold_vld || rd_take;
  assign rx_load   = rx_valid && rx_ready;
  assign txe_n     = (cnt == FULL);
  assign wr_take   = !host_wr_n && !txe_n && !rd_claim;
  assign tx_valid  = (cnt != '0);
  assign tx_pop    = tx_valid && tx_ready;
  assign tx_data   = mem[rptr];
  assign rxf_n     = !hold_vld;
  assign bus_out   = hold_data;
  assign bus_drive = oe_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_vld  <= 1'b0;
      hold_data <= '0;
      oe_q      <= 1'b0;
    end else begin
      oe_q <= !host_oe_n;
      if (rx_load) begin
        hold_vld  <= 1'b1;
        hold_data <= rx_data;
      end else if (rd_take) begin
        hold_vld <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_take) mem[wptr] <= bus_in;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (wr_take) wptr <= wptr + PTR_W'(1);
      if (tx_pop)  rptr <= rptr + PTR_W'(1);
      cnt <= cnt + CNT_W'(wr_take) - CNT_W'(tx_pop);
    end
  end

  AST_RXF_RISE_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rxf_n) |-> $past(!host_rd_n && !host_oe_n)); // R4
  AST_HELD_BYTE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (!rxf_n && (host_rd_n || host_oe_n)) |=> (!rxf_n && $stable(bus_out))); // R6
  AST_DRIVE_AFTER_OE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_drive |-> $past(!host_oe_n)); // R5
  AST_FULL_STAYS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (txe_n && !tx_ready) |=> txe_n); // R8
  AST_TX_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data))); // R7
  AST_READ_BEATS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (!host_rd_n && !host_oe_n && !tx_valid) |=> !tx_valid); // R9

endmodule

// File: tb/burst_fifo_port_tb.sv
module burst_fifo_port_tb_top;
  localparam int DW = 8;
  localparam int DEPTH = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic oe = 1'b1, rd = 1'b1, wr = 1'b1;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] rx_data = '0;
  logic rx_valid = 1'b0, tx_ready = 1'b0;
  logic clk_out, bus_drive, rxf_n, txe_n, rx_ready, tx_valid;
  logic [DW-1:0] bus_out, tx_data;

  bit src_en = 1'b0;
  bit last_oe = 1'b1;
  logic [DW-1:0] src_q[$];
  logic [DW-1:0] exp_rd[$];
  logic [DW-1:0] exp_tx[$];
  int compared = 0, mismatched = 0;
  int pops = 0;

  // bits: oe_n, rd_n, wr_n, source enabled, sink ready
  localparam logic [4:0] VEC [16] = '{
    5'b11111, 5'b01111, 5'b00111, 5'b00111, 5'b00011, 5'b10011, 5'b11010, 5'b11010,
    5'b00110, 5'b00110, 5'b00101, 5'b01001, 5'b01011, 5'b00011, 5'b11111, 5'b11101};

  always #10 clk = ~clk;

  burst_fifo_port #(.DW(DW), .TX_DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .clk_out(clk_out),
    .host_oe_n(oe), .host_rd_n(rd), .host_wr_n(wr), .bus_in(din),
    .bus_out(bus_out), .bus_drive(bus_drive), .rxf_n(rxf_n), .txe_n(txe_n),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic refresh();
    rx_valid = src_en && (src_q.size() > 0);
    rx_data  = (src_q.size() > 0) ? src_q[0] : '0;
  endtask

  task automatic step();
    bit rd_f, wr_f, rx_hs, tx_hs;
    @(negedge clk);
    rd_f  = !rd && !oe && !rxf_n;
    wr_f  = !wr && !txe_n && !(!rd && !oe);
    rx_hs = rx_valid && rx_ready;
    tx_hs = tx_valid && tx_ready;
    chk(bus_drive == !last_oe, "R5 bus_drive", bus_drive, !last_oe);
    if (rd_f) begin
      if (exp_rd.size() == 0) chk(1'b0, "R3 unexpected read byte", bus_out, 0);
      else begin
        chk(bus_out == exp_rd[0], "R3 read byte order", bus_out, exp_rd[0]);
        void'(exp_rd.pop_front());
      end
    end
    if (tx_hs) begin
      pops++;
      if (exp_tx.size() == 0) chk(1'b0, "R7 unexpected tx byte", tx_data, 0);
      else begin
        chk(tx_data == exp_tx[0], "R7 tx byte order", tx_data, exp_tx[0]);
        void'(exp_tx.pop_front());
      end
    end
    if (wr_f) exp_tx.push_back(din);
    if (rx_hs) exp_rd.push_back(rx_data);
    @(posedge clk);
    #1;
    last_oe = oe;
    if (rx_hs) void'(src_q.pop_front());
    refresh();
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  initial begin
    #(20 * 20000);
    compared++;
    mismatched++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic [DW-1:0] held;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    chk(rxf_n == 1'b1, "R1 rxf_n after reset", rxf_n, 1);
    chk(txe_n == 1'b0, "R1 txe_n after reset", txe_n, 0);
    chk(bus_drive == 1'b0, "R1 bus_drive after reset", bus_drive, 0);
    chk(tx_valid == 1'b0, "R1 tx_valid after reset", tx_valid, 0);

    // R2 prefetch, then R5 drive after oe
    src_q.push_back(8'hC1);
    src_en = 1'b1; refresh();
    step();
    chk(rxf_n == 1'b0, "R2 rxf_n after prefetch", rxf_n, 0);
    chk(bus_out == 8'hC1, "R2 byte on bus", bus_out, 8'hC1);
    oe = 1'b0;
    step();
    chk(bus_drive == 1'b1, "R5 drive after oe low", bus_drive, 1);

    // R6 read strobe without oe
    oe = 1'b1; rd = 1'b0;
    step(); step();
    chk(rxf_n == 1'b0, "R6 byte kept", rxf_n, 0);
    chk(bus_out == 8'hC1, "R6 bus unchanged", bus_out, 8'hC1);

    // R9 read and write together, oe low: write ignored
    oe = 1'b0; wr = 1'b0; din = 8'h77; tx_ready = 1'b0;
    step();
    chk(tx_valid == 1'b0, "R9 write ignored with oe low", tx_valid, 0);
    chk(rxf_n == 1'b1, "R4 rxf_n high after last byte", rxf_n, 1);
    // R9 oe high: write performed
    oe = 1'b1; din = 8'h78;
    step();
    chk(tx_valid == 1'b1, "R9 write taken with oe high", tx_valid, 1);
    chk(tx_data == 8'h78, "R9 written byte", tx_data, 8'h78);
    wr = 1'b1; rd = 1'b1; tx_ready = 1'b1;
    step();
    chk(tx_valid == 1'b0, "R7 buffer drained", tx_valid, 0);

    // R3/R4 exact end of a burst of three
    tx_ready = 1'b0;
    src_q.push_back(8'hD0); src_q.push_back(8'hD1); src_q.push_back(8'hD2);
    refresh();
    step();
    chk(bus_out == 8'hD0, "R3 first burst byte", bus_out, 8'hD0);
    rd = 1'b0; oe = 1'b0;
    step();
    chk(rxf_n == 1'b0 && bus_out == 8'hD1, "R3 second burst byte", {rxf_n, bus_out}, {1'b0, 8'hD1});
    step();
    chk(rxf_n == 1'b0 && bus_out == 8'hD2, "R3 third burst byte", {rxf_n, bus_out}, {1'b0, 8'hD2});
    step();
    chk(rxf_n == 1'b1, "R4 end of burst", rxf_n, 1);
    rd = 1'b1; oe = 1'b1;

    // R8 fill with sink stalled, extra writes discarded
    wr = 1'b0;
    for (int i = 0; i < DEPTH + 2; i++) begin
      din = 8'hE0 + 8'(i);
      step();
      chk(txe_n == (i >= DEPTH - 1), "R8 txe_n during fill", txe_n, (i >= DEPTH - 1));
    end
    wr = 1'b1; tx_ready = 1'b1; pops = 0;
    for (int i = 0; i < DEPTH + 2; i++) step();
    chk(pops == DEPTH, "R8 bytes kept after full", pops, DEPTH);
    chk(tx_valid == 1'b0 && txe_n == 1'b0, "R8 drained", {tx_valid, txe_n}, 0);

    // mixed vector walk against reference queues
    for (int k = 0; k < 24; k++) src_q.push_back(8'hA0 + 8'(k));
    for (int i = 0; i < 16; i++) begin
      {oe, rd, wr} = VEC[i][4:2];
      src_en = VEC[i][1];
      tx_ready = VEC[i][0];
      din = 8'h50 + 8'(i);
      refresh();
      step();
    end
    oe = 1'b1; rd = 1'b1; wr = 1'b1; tx_ready = 1'b1; src_en = 1'b0; refresh();
    for (int i = 0; i < DEPTH + 2; i++) step();
    chk(exp_tx.size() == 0, "R7 all written bytes delivered", exp_tx.size(), 0);
    oe = 1'b0; rd = 1'b0;
    for (int i = 0; i < 3; i++) step();
    chk(exp_rd.size() == 0, "R3 all source bytes read", exp_rd.size(), 0);

    summary();
    $finish;
  end
endmodule